// File: doc/BRIEF.md
# Instruction Parcel Unpacker

This block sits at the front of an instruction pipeline whose program words are 60 bits wide. Each word holds a mix of 15-bit and 30-bit instructions. The block fetches words over a request/acknowledge handshake. It walks through each word from its most significant end and hands every instruction downstream, already split into fields, over a valid/ready handshake.

The length of each instruction comes from its function code. One function code takes its length from its i designator instead. A bit-offset pointer tracks how much of the current word is still unused. When a word is used up, the program address steps on and the next word is requested. A long instruction that starts in the final 15 bits of a word cannot fit. That case is presented as an illegal-instruction indication, and the unit then stops until it is redirected.

A flush input drops whatever is left of the current word and restarts fetch at a new address. Execution of the decoded instructions belongs to later stages.

Top module: `parcel_unpacker`

## Requirements
- R1: Each word is consumed from bit 59 downward. The offset is 60 when a word arrives and drops by 15 or 30 for each instruction accepted, so an instruction always starts at offset 60, 45, 30 or 15.
- R2: With offset o, the function code is word bits [o-1:o-6], i is bits [o-7:o-9] and j is bits [o-10:o-12].
- R3: A 15-bit instruction reports k from bits [o-13:o-15] and an address field of zero.
- R4: A 30-bit instruction reports an 18-bit address from bits [o-13:o-30] and a k field of zero.
- R5: Function codes octal 02 to 07, 50 to 52, 60 to 62 and 70 to 72 are 30 bits long (ins_long_o=1). Code 00 and every other code except 01 are 15 bits long.
- R6: Function code octal 01 is 30 bits long when i is 0 to 3 and 15 bits long when i is 4 to 7.
- R7: A 30-bit instruction found at offset 15 is presented with ins_illegal_o=1 instead of as a decoded instruction. Once that indication is accepted, ins_valid_o and fetch_req_o stay low until a flush.
- R8: When the offset reaches 0, the program address increments modulo 2^18, a new fetch is requested at that address, and the new word starts at offset 60.
- R9: A flush discards the current word, drops ins_valid_o in the next cycle, and requests a fetch at flush_addr_i. The first instruction after the flush comes from offset 60 of the word at that address.
- R10: While ins_valid_o is high and ins_ready_i is low, every decoded output holds its value. No later instruction appears until the handshake completes.
- R11: After reset, fetch_req_o is high with fetch_addr_o=0 and ins_valid_o is low. A request holds its address until fetch_ack_i, and the word is taken in the cycle of the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_req_o | output | 1 | Word fetch request |
| fetch_addr_o | output | 18 | Program address of the requested word |
| fetch_ack_i | input | 1 | Fetch acknowledge, qualifies fetch_word_i |
| fetch_word_i | input | 60 | Fetched instruction word |
| flush_i | input | 1 | Discard the current word and restart fetch |
| flush_addr_i | input | 18 | Restart address for flush |
| ins_valid_o | output | 1 | Decoded instruction or illegal indication present |
| ins_ready_i | input | 1 | Downstream accepts the instruction |
| ins_fc_o | output | 6 | Function code |
| ins_i_o | output | 3 | i designator |
| ins_j_o | output | 3 | j designator |
| ins_k_o | output | 3 | k designator, zero for 30-bit instructions |
| ins_addr_o | output | 18 | Address field, zero for 15-bit instructions |
| ins_long_o | output | 1 | Instruction is 30 bits long |
| ins_illegal_o | output | 1 | Long instruction would cross the word boundary |

## Verification
A word acknowledged at a clock edge produces its first decoded instruction in the cycle that follows. An accepted instruction is replaced by the next parcel at the same edge. An exhausted word, a flush and an accepted illegal indication each show up on fetch_req_o and fetch_addr_o one edge later. The bench drives inputs on falling edges and reads every output on the falling edge after the edge that changes it. For each case it walks the handshake forward one edge at a time, so it never samples an output before that output is due.

// File: rtl/parcel_pkg.sv
package parcel_pkg;
  localparam int FC_W  = 6;
  localparam int REG_W = 3;
endpackage

// File: rtl/parcel_len_dec.sv
module parcel_len_dec
  import parcel_pkg::*;
(
  input  logic [FC_W-1:0]  fc_i,
  input  logic [REG_W-1:0] i_i,
  output logic             long_o
);
  logic [2:0] grp, sub;
  assign grp = fc_i[5:3];
  assign sub = fc_i[2:0];

  always_comb begin
    unique case (grp)
      3'd0:    long_o = (sub >= 3'd2) || (sub == 3'd1 && !i_i[REG_W-1]);
      3'd5,
      3'd6,
      3'd7:    long_o = (sub <= 3'd2);
      default: long_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/parcel_field_ext.sv
module parcel_field_ext
  import parcel_pkg::*;
#(
  parameter int WORD_W = 60,
  parameter int ADDR_W = 18,
  parameter int OFF_W  = 6
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              long_i,
  output logic [FC_W-1:0]   fc_o,
  output logic [REG_W-1:0]  i_o,
  output logic [REG_W-1:0]  j_o,
  output logic [REG_W-1:0]  k_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int TAIL = WORD_W - FC_W - 2*REG_W;

  logic [OFF_W-1:0]  sh;
  logic [WORD_W-1:0] aligned;

  // left-justify the current parcel
  assign sh      = OFF_W'(WORD_W) - off_i;
  assign aligned = word_i << sh;

  assign fc_o   = aligned[WORD_W-1 -: FC_W];
  assign i_o    = aligned[WORD_W-FC_W-1 -: REG_W];
  assign j_o    = aligned[WORD_W-FC_W-REG_W-1 -: REG_W];
  assign k_o    = long_i ? '0 : aligned[TAIL-1 -: REG_W];
  assign addr_o = long_i ? aligned[TAIL-1 -: ADDR_W] : '0;
endmodule

// File: rtl/parcel_unpacker.sv
module parcel_unpacker
  import parcel_pkg::*;
#(
  parameter int WORD_W   = 60,
  parameter int PARCEL_W = 15,
  parameter int ADDR_W   = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              fetch_req_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  input  logic              fetch_ack_i,
  input  logic [WORD_W-1:0] fetch_word_i,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_addr_i,
  output logic              ins_valid_o,
  input  logic              ins_ready_i,
  output logic [FC_W-1:0]   ins_fc_o,
  output logic [REG_W-1:0]  ins_i_o,
  output logic [REG_W-1:0]  ins_j_o,
  output logic [REG_W-1:0]  ins_k_o,
  output logic [ADDR_W-1:0] ins_addr_o,
  output logic              ins_long_o,
  output logic              ins_illegal_o
);
  localparam int OFF_W    = $clog2(WORD_W + 1);
  localparam int LONG_LEN = 2 * PARCEL_W;

  logic [WORD_W-1:0] word_q;
  logic [OFF_W-1:0]  off_q, off_nxt;
  logic [ADDR_W-1:0] pc_q;
  logic              have_q, halt_q;
  logic              fire, is_long;

  parcel_len_dec i_len (
    .fc_i   (ins_fc_o),
    .i_i    (ins_i_o),
    .long_o (is_long)
  );

  parcel_field_ext #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_ext (
    .word_i (word_q),
    .off_i  (off_q),
    .long_i (is_long),
    .fc_o   (ins_fc_o),
    .i_o    (ins_i_o),
    .j_o    (ins_j_o),
    .k_o    (ins_k_o),
    .addr_o (ins_addr_o)
  );

  assign ins_long_o    = is_long;
  assign ins_illegal_o = is_long && (off_q < OFF_W'(LONG_LEN));
  assign ins_valid_o   = have_q && !halt_q;
  assign fetch_req_o   = !have_q && !halt_q;
  assign fetch_addr_o  = pc_q;
  assign fire          = ins_valid_o && ins_ready_i;
  assign off_nxt       = off_q - (is_long ? OFF_W'(LONG_LEN) : OFF_W'(PARCEL_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      off_q  <= OFF_W'(WORD_W);
      pc_q   <= '0;
      have_q <= 1'b0;
      halt_q <= 1'b0;
    end else if (flush_i) begin
      off_q  <= OFF_W'(WORD_W);
      pc_q   <= flush_addr_i;
      have_q <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      if (fetch_req_o && fetch_ack_i) begin
        word_q <= fetch_word_i;
        off_q  <= OFF_W'(WORD_W);
        have_q <= 1'b1;
      end
      if (fire) begin
        if (ins_illegal_o) begin
          halt_q <= 1'b1;
          have_q <= 1'b0;
        end else if (off_nxt == '0) begin
          have_q <= 1'b0;
          pc_q   <= pc_q + 1'b1;
          off_q  <= OFF_W'(WORD_W);
        end else begin
          off_q <= off_nxt;
        end
      end
    end
  end

  AST_OFFSET_GRID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    have_q |-> (off_q != '0 && off_q <= OFF_W'(WORD_W) && (off_q % OFF_W'(PARCEL_W)) == '0)); // R1
  AST_SHORT_ADDR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_o && !ins_long_o |-> ins_addr_o == '0); // R3
  AST_LONG_K_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_o && ins_long_o |-> ins_k_o == '0); // R4
  AST_ILLEGAL_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && ins_illegal_o && !flush_i |=> !ins_valid_o && !fetch_req_o); // R7
  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !ins_illegal_o && off_nxt == '0 && !flush_i
    |=> fetch_req_o && fetch_addr_o == ADDR_W'($past(fetch_addr_o) + 1'b1)); // R8
  AST_FLUSH_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !ins_valid_o && fetch_req_o && fetch_addr_o == $past(flush_addr_i)); // R9
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_o && !ins_ready_i && !flush_i
    |=> ins_valid_o && $stable({ins_fc_o, ins_i_o, ins_j_o, ins_k_o, ins_addr_o,
                                ins_long_o, ins_illegal_o})); // R10
  AST_FETCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o && !fetch_ack_i && !flush_i |=> fetch_req_o && $stable(fetch_addr_o)); // R11
endmodule

// File: tb/test_parcel_unpacker.sv
module test_parcel_unpacker;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_req, fetch_ack;
  logic [17:0] fetch_addr, flush_addr = '0;
  logic [59:0] fetch_word;
  logic        flush = 1'b0, ready = 1'b0, ack_en = 1'b0;
  logic        valid, is_long, illegal;
  logic [5:0]  fc;
  logic [2:0]  fi, fj, fk;
  logic [17:0] faddr;
  logic [59:0] mem [0:63];
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign fetch_ack  = fetch_req && ack_en;
  assign fetch_word = mem[fetch_addr[5:0]];

  parcel_unpacker i_parcel_unpacker (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_req_o(fetch_req), .fetch_addr_o(fetch_addr),
    .fetch_ack_i(fetch_ack), .fetch_word_i(fetch_word),
    .flush_i(flush), .flush_addr_i(flush_addr),
    .ins_valid_o(valid), .ins_ready_i(ready),
    .ins_fc_o(fc), .ins_i_o(fi), .ins_j_o(fj), .ins_k_o(fk),
    .ins_addr_o(faddr), .ins_long_o(is_long), .ins_illegal_o(illegal)
  );

  function automatic logic [14:0] mk_s(logic [5:0] c, logic [2:0] i, logic [2:0] j, logic [2:0] k);
    return {c, i, j, k};
  endfunction
  function automatic logic [29:0] mk_l(logic [5:0] c, logic [2:0] i, logic [2:0] j, logic [17:0] a);
    return {c, i, j, a};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // wait for an instruction, compare, accept it
  task automatic take(input logic [5:0] c, input logic [2:0] i, input logic [2:0] j,
                      input logic [2:0] k, input logic [17:0] a, input bit lng, input string tag);
    while (!valid) @(negedge clk);
    chk(fc == c && fi == i && fj == j, {tag, " fc/i/j"}, {fc, fi, fj}, {c, i, j});
    chk(fk == k && faddr == a, {tag, " k/addr"}, {fk, faddr}, {k, a});
    chk(is_long == lng && !illegal, {tag, " long"}, {is_long, illegal}, {lng, 1'b0});
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
  endtask

  task automatic do_flush(input logic [17:0] a);
    flush_addr = a;
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    chk(!valid && fetch_req && fetch_addr == a, "R9 flush restart",
        {valid, fetch_req, fetch_addr}, {1'b0, 1'b1, a});
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(fetch_req && fetch_addr == 0 && !valid, "R11 reset state",
        {fetch_req, fetch_addr, valid}, {1'b1, 18'd0, 1'b0});
    repeat (3) @(negedge clk);
    chk(fetch_req && fetch_addr == 0 && !valid, "R11 request held without ack",
        {fetch_req, fetch_addr, valid}, {1'b1, 18'd0, 1'b0});
    ack_en = 1'b1;
    @(negedge clk);
    chk(valid && !fetch_req, "R11 word taken on ack", {valid, fetch_req}, 2'b10);
  endtask

  task automatic t_hold;
    logic [35:0] snap;
    snap = {fc, fi, fj, fk, faddr, is_long, illegal};
    repeat (4) begin
      @(negedge clk);
      chk(valid && {fc, fi, fj, fk, faddr, is_long, illegal} == snap, "R10 hold stable",
          {fc, fi, fj, fk, faddr, is_long, illegal}, snap);
    end
  endtask

  task automatic t_words;
    take(6'o10, 1, 2, 3, 0, 0, "R1 R2 R3 w0 p0");
    take(6'o00, 7, 0, 5, 0, 0, "R5 code00 short");
    take(6'o17, 4, 4, 4, 0, 0, "R5 code17 short");
    take(6'o77, 6, 5, 1, 0, 0, "R3 w0 p3");
    chk(fetch_req && fetch_addr == 1, "R8 next word addr", {fetch_req, fetch_addr}, {1'b1, 18'd1});
    take(6'o02, 3, 1, 0, 18'h12345, 1, "R4 R5 code02 long");
    take(6'o50, 0, 7, 0, 18'h3FFFF, 1, "R5 code50 long");
    take(6'o01, 2, 6, 0, 18'h00F0F, 1, "R6 code01 i=2 long");
    take(6'o01, 5, 3, 2, 0, 0, "R6 code01 i=5 short");
    take(6'o53, 1, 1, 7, 0, 0, "R5 code53 short");
    take(6'o20, 0, 1, 2, 0, 0, "R1 w3 p0");
    take(6'o60, 5, 5, 0, 18'h2ABCD, 1, "R4 R5 code60 long at 45");
  endtask

  task automatic t_illegal;
    while (!valid) @(negedge clk);
    chk(illegal && fc == 6'o72, "R7 illegal at offset 15", {illegal, fc}, {1'b1, 6'o72});
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
    repeat (4) begin
      chk(!valid && !fetch_req, "R7 halted", {valid, fetch_req}, 2'b00);
      @(negedge clk);
    end
  endtask

  task automatic t_wrap;
    do_flush(18'h3FFFF);
    take(6'o71, 1, 2, 0, 18'h2AAAA, 1, "R9 R5 code71 after flush");
    take(6'o51, 7, 6, 0, 18'h15555, 1, "R5 code51 long");
    chk(fetch_req && fetch_addr == 0, "R8 address wraps", {fetch_req, fetch_addr}, {1'b1, 18'd0});
    take(6'o10, 1, 2, 3, 0, 0, "R8 wrapped word offset 60");
  endtask

  task automatic t_midflush;
    do_flush(18'd2);
    take(6'o01, 2, 6, 0, 18'h00F0F, 1, "R9 mid-word flush new word");
  endtask

  initial begin
    for (int n = 0; n < 64; n++) mem[n] = '0;
    mem[0]  = {mk_s(6'o10, 1, 2, 3), mk_s(6'o00, 7, 0, 5), mk_s(6'o17, 4, 4, 4), mk_s(6'o77, 6, 5, 1)};
    mem[1]  = {mk_l(6'o02, 3, 1, 18'h12345), mk_l(6'o50, 0, 7, 18'h3FFFF)};
    mem[2]  = {mk_l(6'o01, 2, 6, 18'h00F0F), mk_s(6'o01, 5, 3, 2), mk_s(6'o53, 1, 1, 7)};
    mem[3]  = {mk_s(6'o20, 0, 1, 2), mk_l(6'o60, 5, 5, 18'h2ABCD), mk_s(6'o72, 3, 4, 6)};
    mem[63] = {mk_l(6'o71, 1, 2, 18'h2AAAA), mk_l(6'o51, 7, 6, 18'h15555)};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_hold;
    t_words;
    t_illegal;
    t_wrap;
    t_midflush;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule